// File: doc/BRIEF.md
# Two-Wire Slave Bus Front-End with Wiper Stepping

This block is the serial front-end of a multi-channel digital potentiometer controller. It runs on a fast system clock and oversamples the two bus lines, clock and data. It detects the bus framing conditions and checks the first byte of every transfer against a fixed device-type nibble and four strapped pins. It acknowledges by enabling an open-drain pull-down on the data line. The command byte, and a data byte when the command needs one, go to a downstream executor as one-cycle strobes.

For read commands the executor supplies a 6-bit value, which the block shifts out most significant bit first. For the stepping command, every complete clock-high pulse that follows becomes a single up or down step, with the direction taken from the data level. While the executor reports a nonvolatile write in progress, the block withholds the address acknowledge. A master can therefore poll until the write is done.

Both lines pass through a synchronizer before any edge is detected. The system clock must run at least eight times the bus clock, and each bus-clock low phase must last at least HOLD_CYC + 4 system clocks.

Top module: `tw_slave_front`

## Requirements
- R1: A falling data line while the clock is high (START) restarts address reception from any state, including partway through a byte. A rising data line while the clock is high (STOP) returns the block to idle. Bytes clocked without a preceding START are never acknowledged.
- R2: The first byte after START is taken MSB first. It is acknowledged (data pulled low during the ninth clock) only if bits 7:4 equal 0101 and bits 3:0 equal `addrPins`. On a mismatch the block acknowledges nothing and raises no strobe until the next START.
- R3: If `nvBusy` is high when a matching address byte completes, the address is not acknowledged and the transfer is ignored. Once `nvBusy` is low, the same address is acknowledged again.
- R4: After an acknowledged address, the next byte is always acknowledged and presented on `cmdByte` with a one-cycle `cmdValid` pulse. The opcode is bits 7:4.
- R5: For the write opcodes 1010 and 1100, the following byte is acknowledged and its low 6 bits appear on `dataValue` with a one-cycle `dataValid` pulse. Bits 7:6 are dropped. Any further byte is not acknowledged.
- R6: For the read opcodes 1001 and 1011, `rdValue` is sampled when the command acknowledge clock ends. It is then sent as the byte {00, rdValue}, MSB first, and the data line is released during the master's acknowledge clock.
- R7: After the step opcode 0010, each clock-high pulse completed by a clock fall produces one `stepValid` pulse at that fall. `stepUp` is 1 if the data line was high at the rise and 0 if it was low. A pulse that is ended by STOP or START produces no step.
- R8: For every other opcode, no further byte is acknowledged and no data or step strobe is raised.
- R9: The data-line pull-down changes only HOLD_CYC system clocks after a synchronized clock fall, so it never changes while the clock is high. START and STOP release it at once. It is released after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Bus clock line as seen at the pad |
| sdaIn | input | 1 | Bus data line as seen at the pad |
| addrPins | input | 4 | Strapped device address |
| nvBusy | input | 1 | Nonvolatile write in progress; suppresses address acknowledge |
| rdValue | input | VAL_W | Value returned to the master on read commands |
| sdaPullLow | output | 1 | Open-drain enable: 1 pulls the data line low |
| cmdValid | output | 1 | One-cycle strobe: command byte received |
| cmdByte | output | 8 | Last received command byte |
| dataValid | output | 1 | One-cycle strobe: write data received |
| dataValue | output | VAL_W | Received write data (low bits of the byte) |
| stepValid | output | 1 | One-cycle strobe: one wiper step |
| stepUp | output | 1 | Step direction, 1 = up |

## Verification
The properties in the RTL watch every cycle for several things. START must re-arm address reception and STOP must return to idle. No strobe may leave an ignored transfer, and a busy flag at the end of an address byte must block the acknowledge. Steps may only come out of stepping mode, and the pull-down must never move while the clock is high. Only the bench's bus transactions can show the rest. That covers the acknowledge pattern for matching and non-matching addresses, and the values delivered for write and read opcodes, including dropped top bits. It also covers the exact up and down step counts when a final pulse is cut short by STOP, and recovery after a START in the middle of a byte.

// File: rtl/tws_pkg.sv
package tws_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W + 2);

  // bit counter landmarks: last data bit, acknowledge slot, end of acknowledge clock
  localparam logic [CNT_W-1:0] BIT_LAST = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] ACK_SLOT = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] CNT_END  = CNT_W'(BYTE_W + 1);

  localparam logic [3:0] DEV_TYPE    = 4'b0101;
  localparam logic [3:0] OP_RD_WIPER = 4'b1001;
  localparam logic [3:0] OP_RD_REG   = 4'b1011;
  localparam logic [3:0] OP_WR_WIPER = 4'b1010;
  localparam logic [3:0] OP_WR_REG   = 4'b1100;
  localparam logic [3:0] OP_STEP     = 4'b0010;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_CMD, ST_RX, ST_TX, ST_STEP, ST_IGNORE
  } busState_t;

  typedef struct packed {
    logic clrBits;   // restart bit counter
    logic loadTx;    // capture return value into transmit shifter
    logic shiftTx;   // advance transmit shifter
    logic relDrive;  // release the pull-down immediately
    logic driveLow;  // requested pull-down level for the next launch
  } dpCtl_t;
endpackage

// File: rtl/tws_line_sync.sv
module tws_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sclS,
  output logic sdaS,
  output logic sclRise,
  output logic sclFall,
  output logic startSeen,
  output logic stopSeen
);
  logic [SYNC_STAGES-1:0] sclPipe, sdaPipe;
  logic sclPrev, sdaPrev;

  // idle bus is high, so the pipes reset to ones
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[SYNC_STAGES-2:0], sclIn};
      sdaPipe <= {sdaPipe[SYNC_STAGES-2:0], sdaIn};
      sclPrev <= sclS;
      sdaPrev <= sdaS;
    end
  end

  assign sclS      = sclPipe[SYNC_STAGES-1];
  assign sdaS      = sdaPipe[SYNC_STAGES-1];
  assign sclRise   = sclS & ~sclPrev;
  assign sclFall   = ~sclS & sclPrev;
  assign startSeen = sclS & sclPrev & sdaPrev & ~sdaS;
  assign stopSeen  = sclS & sclPrev & ~sdaPrev & sdaS;
endmodule

// File: rtl/tws_datapath.sv
module tws_datapath
  import tws_pkg::*;
#(
  parameter int VAL_W    = 6,
  parameter int HOLD_CYC = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sclRise,
  input  logic                sclFall,
  input  logic                sdaS,
  input  dpCtl_t              ctl,
  input  logic [VAL_W-1:0]    rdValue,
  output logic [CNT_W-1:0]    bitCnt,
  output logic [BYTE_W-2:0]   rxPart,
  output logic                txBit,
  output logic                sdaPullLow
);
  localparam int HOLD_W = $clog2(HOLD_CYC + 1);
  localparam logic [HOLD_W-1:0] HOLD_LOAD = HOLD_W'(HOLD_CYC);
  localparam logic [HOLD_W-1:0] HOLD_FIRE = HOLD_W'(1);

  logic [BYTE_W-1:0] txShift;
  logic [HOLD_W-1:0] holdCnt;

  // bit counter: one step per clock rise, wraps after the acknowledge clock
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0;
    end else if (ctl.clrBits) begin
      bitCnt <= '0;
    end else if (sclRise && bitCnt != CNT_END) begin
      bitCnt <= bitCnt + 1'b1;
    end else if (sclFall && bitCnt == CNT_END) begin
      bitCnt <= '0;
    end
  end

  // receive shifter keeps the seven earlier bits; the eighth arrives live
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxPart <= '0;
    end else if (sclRise && bitCnt < ACK_SLOT) begin
      rxPart <= {rxPart[BYTE_W-3:0], sdaS};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
    end else if (ctl.loadTx) begin
      txShift <= BYTE_W'(rdValue);
    end else if (ctl.shiftTx) begin
      txShift <= {txShift[BYTE_W-2:0], 1'b0};
    end
  end
  assign txBit = txShift[BYTE_W-1];

  // output launch: a fixed delay after each clock fall gives hold time
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdCnt    <= '0;
      sdaPullLow <= 1'b0;
    end else if (ctl.relDrive) begin
      holdCnt    <= '0;
      sdaPullLow <= 1'b0;
    end else if (sclFall) begin
      holdCnt <= HOLD_LOAD;
    end else if (holdCnt != '0) begin
      holdCnt <= holdCnt - 1'b1;
      if (holdCnt == HOLD_FIRE) sdaPullLow <= ctl.driveLow;
    end
  end

  // R1: framing conditions free the data line on the next cycle
  p_release_r1: assert property (@(posedge clk) disable iff (!rstN)
    ctl.relDrive |=> !sdaPullLow);
endmodule

// File: rtl/tws_control.sv
module tws_control
  import tws_pkg::*;
#(
  parameter int VAL_W = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sclRise,
  input  logic               sclFall,
  input  logic               sdaS,
  input  logic               startSeen,
  input  logic               stopSeen,
  input  logic [3:0]         addrPins,
  input  logic               nvBusy,
  input  logic [CNT_W-1:0]   bitCnt,
  input  logic [BYTE_W-2:0]  rxPart,
  input  logic               txBit,
  output dpCtl_t             ctl,
  output logic               cmdValid,
  output logic [BYTE_W-1:0]  cmdByte,
  output logic               dataValid,
  output logic [VAL_W-1:0]   dataValue,
  output logic               stepValid,
  output logic               stepUp
);
  busState_t state;
  logic ackPend, stepPend, stepDir;
  logic [BYTE_W-1:0] byteWord;
  logic addrHit, cmdIsRead, cmdIsWrite, cmdIsStep, ackEnd;

  assign byteWord   = {rxPart, sdaS};
  assign addrHit    = (byteWord[7:4] == DEV_TYPE) && (byteWord[3:0] == addrPins);
  assign cmdIsRead  = (cmdByte[7:4] == OP_RD_WIPER) || (cmdByte[7:4] == OP_RD_REG);
  assign cmdIsWrite = (cmdByte[7:4] == OP_WR_WIPER) || (cmdByte[7:4] == OP_WR_REG);
  assign cmdIsStep  = (cmdByte[7:4] == OP_STEP);
  assign ackEnd     = sclFall && (bitCnt == CNT_END);

  always_comb begin
    ctl          = '0;
    ctl.clrBits  = startSeen | stopSeen;
    ctl.relDrive = startSeen | stopSeen;
    ctl.loadTx   = ackEnd && (state == ST_CMD) && cmdIsRead;
    ctl.shiftTx  = sclFall && (state == ST_TX) && (bitCnt != '0) && (bitCnt < ACK_SLOT);
    ctl.driveLow = ((bitCnt == ACK_SLOT) && ackPend) ||
                   ((state == ST_TX) && (bitCnt < ACK_SLOT) && !txBit);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      ackPend   <= 1'b0;
      stepPend  <= 1'b0;
      stepDir   <= 1'b0;
      cmdValid  <= 1'b0;
      cmdByte   <= '0;
      dataValid <= 1'b0;
      dataValue <= '0;
      stepValid <= 1'b0;
      stepUp    <= 1'b0;
    end else begin
      cmdValid  <= 1'b0;
      dataValid <= 1'b0;
      stepValid <= 1'b0;
      if (startSeen) begin
        state    <= ST_ADDR;
        ackPend  <= 1'b0;
        stepPend <= 1'b0;
      end else if (stopSeen) begin
        state    <= ST_IDLE;
        ackPend  <= 1'b0;
        stepPend <= 1'b0;
      end else begin
        // byte completes on the eighth rise
        if (sclRise && bitCnt == BIT_LAST) begin
          unique case (state)
            ST_ADDR: ackPend <= addrHit && !nvBusy;
            ST_CMD: begin
              ackPend  <= 1'b1;
              cmdByte  <= byteWord;
              cmdValid <= 1'b1;
            end
            ST_RX: begin
              ackPend   <= 1'b1;
              dataValue <= byteWord[VAL_W-1:0];
              dataValid <= 1'b1;
            end
            default: ;
          endcase
        end
        // stepping: arm on rise, commit on the fall that completes the pulse
        if (state == ST_STEP && sclRise) begin
          stepPend <= 1'b1;
          stepDir  <= sdaS;
        end
        if (state == ST_STEP && sclFall && stepPend) begin
          stepValid <= 1'b1;
          stepUp    <= stepDir;
          stepPend  <= 1'b0;
        end
        // phase change at the end of the acknowledge clock
        if (ackEnd) begin
          ackPend <= 1'b0;
          unique case (state)
            ST_ADDR: state <= ackPend ? ST_CMD : ST_IGNORE;
            ST_CMD: begin
              if (cmdIsRead)       state <= ST_TX;
              else if (cmdIsWrite) state <= ST_RX;
              else if (cmdIsStep)  state <= ST_STEP;
              else                 state <= ST_IGNORE;
            end
            ST_RX:   state <= ST_IGNORE;
            ST_TX:   state <= ST_IGNORE;
            default: ;
          endcase
        end
      end
    end
  end

  // R1: START re-arms address reception, STOP parks the block
  p_start_rearm_r1: assert property (@(posedge clk) disable iff (!rstN)
    startSeen |=> (state == ST_ADDR));
  p_stop_idle_r1: assert property (@(posedge clk) disable iff (!rstN)
    stopSeen |=> (state == ST_IDLE) && !ackPend);
  // R2: an ignored transfer emits nothing
  p_ignore_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IGNORE && $past(state) == ST_IGNORE) |-> !(cmdValid || dataValid || stepValid));
  // R3: busy flag at address completion blocks the acknowledge
  p_busy_nack_r3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ADDR && sclRise && bitCnt == BIT_LAST && nvBusy) |=> !ackPend);
  // R4: command strobe only from the command phase
  p_cmd_phase_r4: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> $past(state) == ST_CMD);
  // R7: steps only leave stepping mode
  p_step_mode_r7: assert property (@(posedge clk) disable iff (!rstN)
    stepValid |-> $past(state) == ST_STEP);
endmodule

// File: rtl/tw_slave_front.sv
module tw_slave_front
  import tws_pkg::*;
#(
  parameter int VAL_W       = 6,
  parameter int SYNC_STAGES = 2,
  parameter int HOLD_CYC    = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [3:0]        addrPins,
  input  logic              nvBusy,
  input  logic [VAL_W-1:0]  rdValue,
  output logic              sdaPullLow,
  output logic              cmdValid,
  output logic [7:0]        cmdByte,
  output logic              dataValid,
  output logic [VAL_W-1:0]  dataValue,
  output logic              stepValid,
  output logic              stepUp
);
  logic sclS, sdaS, sclRise, sclFall, startSeen, stopSeen, txBit;
  logic [CNT_W-1:0]  bitCnt;
  logic [BYTE_W-2:0] rxPart;
  dpCtl_t ctl;

  tws_line_sync #(.SYNC_STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sclS(sclS), .sdaS(sdaS), .sclRise(sclRise), .sclFall(sclFall),
    .startSeen(startSeen), .stopSeen(stopSeen)
  );

  tws_control #(.VAL_W(VAL_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .sclRise(sclRise), .sclFall(sclFall), .sdaS(sdaS),
    .startSeen(startSeen), .stopSeen(stopSeen), .addrPins(addrPins), .nvBusy(nvBusy),
    .bitCnt(bitCnt), .rxPart(rxPart), .txBit(txBit), .ctl(ctl),
    .cmdValid(cmdValid), .cmdByte(cmdByte), .dataValid(dataValid), .dataValue(dataValue),
    .stepValid(stepValid), .stepUp(stepUp)
  );

  tws_datapath #(.VAL_W(VAL_W), .HOLD_CYC(HOLD_CYC)) i_dp (
    .clk(clk), .rstN(rstN), .sclRise(sclRise), .sclFall(sclFall), .sdaS(sdaS),
    .ctl(ctl), .rdValue(rdValue), .bitCnt(bitCnt), .rxPart(rxPart),
    .txBit(txBit), .sdaPullLow(sdaPullLow)
  );

  // R9: outside framing releases, the pull-down moves only while the clock is low
  p_sda_quiet_high_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(sdaPullLow) && !$past(startSeen || stopSeen)) |-> !sclS);
endmodule

// File: tb/test_tw_slave_front.sv
`timescale 1ns/1ps
module test_tw_slave_front;
  localparam int HALF  = 8;
  localparam int LIMIT = 150000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic scl = 1'b1;
  logic sdaM = 1'b1;
  logic [3:0] addrPins = 4'b0110;
  logic nvBusy = 1'b0;
  logic [5:0] rdValue = '0;
  logic sdaPullLow, cmdValid, dataValid, stepValid, stepUp;
  logic [7:0] cmdByte;
  logic [5:0] dataValue;
  wire sdaLine = sdaM & ~sdaPullLow;

  int vecCount = 0, missCount = 0, cyc = 0;
  int cmdSeen = 0, dataSeen = 0, upSeen = 0, dnSeen = 0;
  int edgeViol = 0, sinceFall = 0;
  logic [7:0] lastCmd = '0;
  logic [5:0] lastData = '0;
  logic prevDrive = 1'b0, prevScl = 1'b1;
  bit done = 0;

  always #5 clk = ~clk;

  tw_slave_front i_tw_slave_front (
    .clk(clk), .rstN(rstN), .sclIn(scl), .sdaIn(sdaLine), .addrPins(addrPins),
    .nvBusy(nvBusy), .rdValue(rdValue), .sdaPullLow(sdaPullLow),
    .cmdValid(cmdValid), .cmdByte(cmdByte), .dataValid(dataValid),
    .dataValue(dataValue), .stepValid(stepValid), .stepUp(stepUp)
  );

  always @(negedge clk) begin
    if (cmdValid)  begin cmdSeen++;  lastCmd = cmdByte; end
    if (dataValid) begin dataSeen++; lastData = dataValue; end
    if (stepValid) begin if (stepUp) upSeen++; else dnSeen++; end
    // R9 monitor: drive changes only in clock low, at least two cycles after the fall
    if (prevScl && !scl) sinceFall = 0; else sinceFall++;
    if (sdaPullLow != prevDrive && (scl || sinceFall < 2)) edgeViol++;
    prevDrive = sdaPullLow;
    prevScl = scl;
  end

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == LIMIT && !done) begin
      missCount++;
      $display("FAIL watchdog: actual %0d cycles expected < %0d", cyc, LIMIT);
      summary();
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vecCount++;
    if (!ok) begin
      missCount++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic waitC(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one bus clock: data set two cycles into low, sampled late in high
  task automatic xferBit(input logic drv, output logic seen);
    sdaM = drv;
    waitC(HALF - 2);
    scl = 1'b1;
    waitC(HALF - 2);
    seen = sdaLine;
    waitC(2);
    scl = 1'b0;
    waitC(2);
  endtask

  task automatic busStart();
    sdaM = 1'b1;
    if (!scl) begin waitC(HALF - 2); scl = 1'b1; end
    waitC(HALF);
    sdaM = 1'b0;
    waitC(HALF);
    scl = 1'b0;
    waitC(2);
  endtask

  task automatic busStop();
    sdaM = 1'b0;
    waitC(HALF - 2);
    scl = 1'b1;
    waitC(HALF);
    sdaM = 1'b1;
    waitC(HALF);
  endtask

  task automatic sendByte(input logic [7:0] b, output bit ack);
    logic s;
    for (int i = 7; i >= 0; i--) xferBit(b[i], s);
    xferBit(1'b1, s);
    ack = !s;
  endtask

  task automatic readByte(output logic [7:0] v, input bit mAck);
    logic s;
    for (int i = 7; i >= 0; i--) begin xferBit(1'b1, s); v[i] = s; end
    xferBit(!mAck, s);
  endtask

  function automatic bit expAddrAck(input logic [7:0] a, input logic [3:0] pins, input logic busy);
    return (a[7:4] == 4'b0101) && (a[3:0] == pins) && !busy;
  endfunction

  function automatic logic [7:0] pickCmd(input int k, input logic [3:0] sel);
    case (k)
      0: return {4'b1010, sel};
      1: return {4'b1100, sel};
      2: return {4'b1001, sel};
      3: return {4'b1011, sel};
      4: return {4'b0010, sel};
      default: return {4'b1101, sel};
    endcase
  endfunction

  task automatic randomTxn();
    logic [31:0] r;
    logic [7:0] addr, cmd, dat, got;
    bit ack, expA;
    int k, n, up0, dn0, eUp, eDn, c0, d0;
    logic s;
    r = $urandom;
    addrPins = r[3:0];
    addr = r[4] ? {4'b0101, r[3:0]} : r[15:8];
    cmd = pickCmd(int'(r[18:16]) % 6, r[23:20]);
    k = int'(r[18:16]) % 6;
    rdValue = r[29:24];
    expA = expAddrAck(addr, addrPins, 1'b0);
    c0 = cmdSeen; d0 = dataSeen;
    busStart();
    sendByte(addr, ack);
    check(ack == expA, "R2 random address ack", ack, expA);
    if (!ack) begin
      sendByte(r[31:24], ack);
      check(!ack && cmdSeen == c0, "R2 ignored after mismatch", ack, 0);
      busStop();
      return;
    end
    sendByte(cmd, ack);
    check(ack && cmdSeen == c0 + 1 && lastCmd == cmd, "R4 random command", lastCmd, cmd);
    case (k)
      0, 1: begin
        r = $urandom;
        dat = r[7:0];
        sendByte(dat, ack);
        check(ack && dataSeen == d0 + 1 && lastData == dat[5:0], "R5 random write", lastData, dat[5:0]);
      end
      2, 3: begin
        readByte(got, 1'b1);
        check(got == {2'b00, rdValue}, "R6 random read", got, {2'b00, rdValue});
      end
      4: begin
        r = $urandom;
        n = 1 + int'(r[2:0]);
        up0 = upSeen; dn0 = dnSeen; eUp = 0; eDn = 0;
        for (int i = 0; i < n; i++) begin
          xferBit(r[8 + i], s);
          if (r[8 + i]) eUp++; else eDn++;
        end
        busStop();
        waitC(6);
        check(upSeen - up0 == eUp, "R7 random up steps", upSeen - up0, eUp);
        check(dnSeen - dn0 == eDn, "R7 random down steps", dnSeen - dn0, eDn);
        return;
      end
      default: begin
        sendByte(8'h3C, ack);
        check(!ack && dataSeen == d0, "R8 transfer opcode extra byte", ack, 0);
      end
    endcase
    busStop();
  endtask

  initial begin : main
    bit ack;
    logic s;
    logic [7:0] got;
    int c0, d0, u0, n0;
    void'($urandom(32'd20240611));
    waitC(5);
    rstN = 1'b1;
    waitC(5);

    // R9 reset state
    check(sdaPullLow == 1'b0 && cmdSeen == 0, "R9 reset released", sdaPullLow, 0);

    // R1 no START: matching byte is not acknowledged
    scl = 1'b0; waitC(2);
    sendByte(8'h56, ack);
    check(!ack, "R1 byte without START", ack, 0);
    busStop();

    // R2 wrong type nibble and wrong pins
    busStart();
    sendByte(8'h76, ack);
    check(!ack, "R2 wrong device type", ack, 0);
    sendByte(8'hA0, ack);
    check(!ack && cmdSeen == 0, "R2 bytes after mismatch", cmdSeen, 0);
    busStop();
    busStart();
    sendByte(8'h57, ack);
    check(!ack, "R2 wrong address pins", ack, 0);
    busStop();

    // R4/R5 write wiper with data
    busStart();
    sendByte(8'h56, ack);
    check(ack, "R2 matching address", ack, 1);
    sendByte(8'hA2, ack);
    check(ack && lastCmd == 8'hA2, "R4 command byte", lastCmd, 8'hA2);
    sendByte(8'h2A, ack);
    check(ack && lastData == 6'h2A, "R5 write data", lastData, 6'h2A);
    d0 = dataSeen;
    sendByte(8'h11, ack);
    check(!ack && dataSeen == d0, "R5 second data byte refused", ack, 0);
    busStop();

    // R5 top bits dropped
    busStart();
    sendByte(8'h56, ack);
    sendByte(8'hC7, ack);
    sendByte(8'hFF, ack);
    check(ack && lastData == 6'h3F, "R5 top bits dropped", lastData, 6'h3F);
    busStop();

    // R6 reads
    rdValue = 6'h15;
    busStart();
    sendByte(8'h56, ack);
    sendByte(8'h91, ack);
    readByte(got, 1'b1);
    check(got == 8'h15, "R6 read wiper value", got, 8'h15);
    busStop();
    rdValue = 6'h2C;
    busStart();
    sendByte(8'h56, ack);
    sendByte(8'hB3, ack);
    readByte(got, 1'b0);
    check(got == 8'h2C, "R6 read register value", got, 8'h2C);
    busStop();

    // R3 busy polling
    nvBusy = 1'b1;
    c0 = cmdSeen;
    busStart();
    sendByte(8'h56, ack);
    check(!ack, "R3 busy withholds ack", ack, 0);
    sendByte(8'hA0, ack);
    check(!ack && cmdSeen == c0, "R3 busy transfer ignored", cmdSeen, c0);
    busStop();
    nvBusy = 1'b0;
    busStart();
    sendByte(8'h56, ack);
    check(ack, "R3 ack after busy clears", ack, 1);
    busStop();

    // R8 two-byte transfer opcode
    d0 = dataSeen;
    busStart();
    sendByte(8'h56, ack);
    sendByte(8'hD4, ack);
    check(ack, "R4 transfer command acked", ack, 1);
    sendByte(8'h05, ack);
    check(!ack && dataSeen == d0, "R8 no data after transfer", ack, 0);
    busStop();

    // R1 START in the middle of a byte, then a clean address
    busStart();
    for (int i = 7; i >= 4; i--) xferBit(got[i] ^ 1'b1, s);
    busStart();
    sendByte(8'h56, ack);
    check(ack, "R1 restart mid-byte", ack, 1);
    sendByte(8'hA0, ack);
    for (int i = 7; i >= 3; i--) xferBit(1'b0, s);
    busStart();
    sendByte(8'h56, ack);
    check(ack, "R1 restart inside command", ack, 1);
    busStop();

    // R7 directed stepping, final pulse cut by STOP
    u0 = upSeen; n0 = dnSeen;
    busStart();
    sendByte(8'h56, ack);
    sendByte(8'h21, ack);
    check(ack, "R7 step command acked", ack, 1);
    xferBit(1'b1, s); xferBit(1'b1, s); xferBit(1'b0, s);
    xferBit(1'b1, s); xferBit(1'b0, s);
    waitC(6);
    check(upSeen - u0 == 3, "R7 up steps", upSeen - u0, 3);
    check(dnSeen - n0 == 2, "R7 down steps", dnSeen - n0, 2);
    busStop();
    waitC(6);
    check(dnSeen - n0 == 2, "R7 STOP pulse gives no step", dnSeen - n0, 2);

    // constrained random transactions
    for (int t = 0; t < 40; t++) randomTxn();

    check(edgeViol == 0, "R9 drive timing", edgeViol, 0);
    done = 1;
    summary();
    $finish;
  end
endmodule